// File: doc/BRIEF.md
# Flash Command Sequence State Machine

This block sits behind the write port of a parallel NOR flash and turns the stream of qualified bus writes into device operations. It recognises the two-cycle unlock preamble, the command byte that follows it, and the extra cycles that program and sector erase need. When a sequence is complete it raises a one-cycle start request towards the embedded program or erase engine, and it holds the address, data or sector that goes with that request.

A read-mode output tells the read path what a read at `rd_addr` should return: array contents, the status word, or the identification code. Reads in the normal mode need no command. While an engine operation runs, after the engine reports a timeout, and at suspended sectors during erase suspend, reads return status. Reset commands are accepted, ignored or required depending on the phase the machine is in. Suspend and resume are single-cycle writes that act only around an erase.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After synchronous reset the read mode is array (`rd_mode` = 2'b00; 2'b01 is status, 2'b10 is ID) and no start, suspend or resume request is raised.
- R2: Writes AAh@05555h, 55h@02AAAh, A0h@05555h, then any write other than F0h raise `pgm_start` for the cycle after that fourth write, with `pgm_addr`/`pgm_data` holding its address and data. Reads return status while the program runs, and array after `eng_done`.
- R3: Writes AAh@05555h, 55h@02AAAh, 80h@05555h, AAh@05555h, 55h@02AAAh, then 30h at any address raise `erase_start` for one cycle, with `erase_sector` holding address bits [16:14] of the last write. Reads return status while the erase runs.
- R4: Writes AAh@05555h, 55h@02AAAh, 90h@05555h select ID reads, which stay selected through any other writes until data F0h is written at any address.
- R5: A write with a wrong address or wrong data inside a sequence returns the machine to the idle mode, so the rest of that sequence starts nothing.
- R6: Data F0h written between the cycles of a sequence returns the machine to the idle mode.
- R7: While a program or erase runs, F0h writes are ignored and reads keep returning status.
- R8: `eng_timeout` during a program or erase selects status reads, which stay until an F0h write returns the machine to its idle mode.
- R9: B0h at any address during an erase raises `suspend_req` for one cycle. Reads in the erasing sector then return status and reads in other sectors return array. A later single write of 30h raises `resume_req` for one cycle and returns to status reads everywhere.
- R10: B0h and 30h written while the machine is idle in array mode raise no request and leave array reads selected.
- R11: During erase suspend a full program sequence raises `pgm_start`. After `eng_done`, the suspended sector still reads status and other sectors read array.
- R12: The ID mode entered from erase suspend is left with F0h, and this returns the machine to erase suspend: the suspended sector reads status and other sectors read array.
- R13: `eng_done` during a running erase returns array reads at every address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Qualified bus write strobe, one cycle per write |
| wr_addr | input | 17 | Address of the write |
| wr_data | input | 8 | Data of the write |
| rd_addr | input | 17 | Address of the current read |
| eng_done | input | 1 | Engine finished the running operation (pulse) |
| eng_timeout | input | 1 | Engine exceeded its time limit (pulse) |
| rd_mode | output | 2 | 00 array, 01 status, 10 ID |
| pgm_start | output | 1 | One-cycle program request |
| pgm_addr | output | 17 | Address for the requested program |
| pgm_data | output | 8 | Data for the requested program |
| erase_start | output | 1 | One-cycle sector erase request |
| erase_sector | output | 3 | Sector for the requested erase |
| suspend_req | output | 1 | One-cycle erase suspend request |
| resume_req | output | 1 | One-cycle erase resume request |

## Verification
The assertions assume that `eng_done` and `eng_timeout` are single-cycle pulses. They also assume these pulses come only after a start or resume request, are never raised together, and never overlap a write. The stimulus keeps to this: it raises each engine pulse on its own, only after it has seen the matching request, and it keeps `wr_en` low in that cycle. Writes are spaced one per strobe with idle cycles between them. Read-mode checks move `rd_addr` between sectors only while no write is being presented.

// File: rtl/flash_cmd_pkg.sv
// Shared types and command codes of the flash command sequencer.
// Assumes an 8-bit command byte in the low bits of the write data.
package flash_cmd_pkg;

    typedef enum logic [3:0] {
        ST_ARRAY,
        ST_UNL1,
        ST_UNL2,
        ST_PGM_ARM,
        ST_ERS_ARM,
        ST_ERS_UNL1,
        ST_ERS_UNL2,
        ST_IDREAD,
        ST_PGM_RUN,
        ST_ERS_RUN,
        ST_SUSPEND,
        ST_FAULT
    } fsm_state_t;

    typedef enum logic [1:0] {
        RD_ARRAY  = 2'b00,
        RD_STATUS = 2'b01,
        RD_IDENT  = 2'b10
    } rd_mode_t;

    localparam logic [7:0] CMD_UNLOCK_A = 8'hAA;
    localparam logic [7:0] CMD_UNLOCK_B = 8'h55;
    localparam logic [7:0] CMD_PROGRAM  = 8'hA0;
    localparam logic [7:0] CMD_SETUP    = 8'h80;
    localparam logic [7:0] CMD_IDENT    = 8'h90;
    localparam logic [7:0] CMD_RESET    = 8'hF0;
    localparam logic [7:0] CMD_SUSPEND  = 8'hB0;
    localparam logic [7:0] CMD_CONFIRM  = 8'h30;

    // One flag per recognised write pattern.
    typedef struct packed {
        logic unl_a;
        logic unl_b;
        logic c_pgm;
        logic c_setup;
        logic c_ident;
        logic c_reset;
        logic c_susp;
        logic c_conf;
    } wr_class_t;

endpackage

// File: rtl/flash_wr_classify.sv
// Classifies one bus write against the known command patterns.
// Purely combinational. Assumes DATA_W >= 8 and the command byte in bits [7:0].
// Only the two unlock cycles and the three unlock-qualified command bytes
// check the address. Reset, suspend and confirm match any address.
module flash_wr_classify
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] UNL_ADDR_A = 17'h05555,
    parameter logic [ADDR_W-1:0] UNL_ADDR_B = 17'h02AAA
) (
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output wr_class_t         cls
);
    logic [7:0] cmd_byte;
    logic       at_a;
    logic       at_b;

    // Compare the write against every pattern.
    always_comb begin
        cmd_byte    = wr_data[7:0];
        at_a        = (wr_addr == UNL_ADDR_A);
        at_b        = (wr_addr == UNL_ADDR_B);
        cls.unl_a   = at_a && (cmd_byte == CMD_UNLOCK_A);
        cls.unl_b   = at_b && (cmd_byte == CMD_UNLOCK_B);
        cls.c_pgm   = at_a && (cmd_byte == CMD_PROGRAM);
        cls.c_setup = at_a && (cmd_byte == CMD_SETUP);
        cls.c_ident = at_a && (cmd_byte == CMD_IDENT);
        cls.c_reset = (cmd_byte == CMD_RESET);
        cls.c_susp  = (cmd_byte == CMD_SUSPEND);
        cls.c_conf  = (cmd_byte == CMD_CONFIRM);
    end

    // Address-qualified patterns can only be seen at their own address.
    always_comb begin
        assert ((!cls.unl_b || (wr_addr == UNL_ADDR_B)) &&
                (!(cls.unl_a || cls.c_pgm) || (wr_addr == UNL_ADDR_A)))
            else $error("a_r5_addr_qualified");
    end
endmodule

// File: rtl/flash_susp_mask.sv
// Per-sector suspended mask. A set marks one sector, a clear wipes all,
// and clear wins over set. The hit output reports the mask bit of the
// sector being read.
module flash_susp_mask #(
    parameter int SECT_BITS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_en,
    input  logic [SECT_BITS-1:0] set_idx,
    input  logic                 clr,
    input  logic [SECT_BITS-1:0] rd_idx,
    output logic                 hit
);
    localparam int NSECT = 1 << SECT_BITS;

    logic [NSECT-1:0] mask_q;

    for (genvar s = 0; s < NSECT; s++) begin : g_sect
        // Hold the suspended flag of sector s.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                mask_q[s] <= 1'b0;
            else if (set_en && (set_idx == SECT_BITS'(s)))
                mask_q[s] <= 1'b1;
        end
    end

    // Select the flag of the sector under read.
    always_comb hit = mask_q[rd_idx];

    // R13: a clear leaves no sector marked.
    a_r13_mask_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (mask_q == '0));

    // R9: a set marks exactly that sector and no more than one at a time.
    a_r9_mask_single: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !clr && (mask_q == '0)) |=> $onehot0(mask_q) && mask_q[$past(set_idx)]);
endmodule

// File: rtl/flash_rd_select.sv
// Chooses what a read returns from the machine state and the suspended
// flag of the addressed sector. Combinational.
module flash_rd_select
    import flash_cmd_pkg::*;
(
    input  fsm_state_t state,
    input  logic       sect_hit,
    output rd_mode_t   rd_mode
);
    // Map state and sector flag to a read mode.
    always_comb begin
        case (state)
            ST_IDREAD:                     rd_mode = RD_IDENT;
            ST_PGM_RUN, ST_ERS_RUN,
            ST_FAULT:                      rd_mode = RD_STATUS;
            default:                       rd_mode = sect_hit ? RD_STATUS : RD_ARRAY;
        endcase
    end
endmodule

// File: rtl/flash_cmd_fsm.sv
// Flash command sequencer top. It tracks unlock and command cycles,
// raises registered one-cycle requests to the embedded engine, and
// selects the read mode. Assumes one write per wr_en pulse. It also
// assumes eng_done/eng_timeout are pulses sent only for a running operation.
// The idle mode is array read, or erase suspend while an erase is parked.
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 8,
    parameter int SECT_BITS = 3,
    parameter logic [ADDR_W-1:0] UNL_ADDR_A = 17'h05555,
    parameter logic [ADDR_W-1:0] UNL_ADDR_B = 17'h02AAA
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    input  logic                 eng_done,
    input  logic                 eng_timeout,
    output logic [1:0]           rd_mode,
    output logic                 pgm_start,
    output logic [ADDR_W-1:0]    pgm_addr,
    output logic [DATA_W-1:0]    pgm_data,
    output logic                 erase_start,
    output logic [SECT_BITS-1:0] erase_sector,
    output logic                 suspend_req,
    output logic                 resume_req
);
    localparam int SECT_LSB = ADDR_W - SECT_BITS;

    wr_class_t             cls;
    fsm_state_t            state_q, state_n, idle_st;
    logic                  susp_q, susp_n;
    logic [SECT_BITS-1:0]  sect_q, sect_n;
    logic                  pgm_n, ers_n, sreq_n, rreq_n, mask_set, mask_clr;
    logic                  sect_hit;
    rd_mode_t              mode_w;
    logic                  unused_rd_bits;

    flash_wr_classify #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .UNL_ADDR_A(UNL_ADDR_A), .UNL_ADDR_B(UNL_ADDR_B)
    ) i_classify (
        .wr_addr(wr_addr), .wr_data(wr_data), .cls(cls)
    );

    flash_susp_mask #(.SECT_BITS(SECT_BITS)) i_mask (
        .clk(clk), .rst_n(rst_n),
        .set_en(mask_set), .set_idx(sect_q), .clr(mask_clr),
        .rd_idx(rd_addr[ADDR_W-1:SECT_LSB]), .hit(sect_hit)
    );

    flash_rd_select i_rdsel (
        .state(state_q), .sect_hit(sect_hit), .rd_mode(mode_w)
    );

    assign rd_mode        = mode_w;
    assign unused_rd_bits = ^rd_addr[SECT_LSB-1:0];

    // Decide the next state and the requests of this cycle.
    always_comb begin
        idle_st  = susp_q ? ST_SUSPEND : ST_ARRAY;
        state_n  = state_q;
        susp_n   = susp_q;
        sect_n   = sect_q;
        pgm_n    = 1'b0;
        ers_n    = 1'b0;
        sreq_n   = 1'b0;
        rreq_n   = 1'b0;
        mask_set = 1'b0;
        mask_clr = 1'b0;
        case (state_q)
            ST_ARRAY: begin
                if (wr_en && cls.unl_a) state_n = ST_UNL1;
            end
            ST_SUSPEND: begin
                if (wr_en && cls.unl_a) begin
                    state_n = ST_UNL1;
                end else if (wr_en && cls.c_conf) begin
                    state_n  = ST_ERS_RUN;
                    susp_n   = 1'b0;
                    mask_clr = 1'b1;
                    rreq_n   = 1'b1;
                end
            end
            ST_UNL1: begin
                if (wr_en) state_n = cls.unl_b ? ST_UNL2 : idle_st;
            end
            ST_UNL2: begin
                if (wr_en) begin
                    if (cls.c_pgm)                  state_n = ST_PGM_ARM;
                    else if (cls.c_setup && !susp_q) state_n = ST_ERS_ARM;
                    else if (cls.c_ident)           state_n = ST_IDREAD;
                    else                            state_n = idle_st;
                end
            end
            ST_PGM_ARM: begin
                if (wr_en) begin
                    if (cls.c_reset) begin
                        state_n = idle_st;
                    end else begin
                        state_n = ST_PGM_RUN;
                        pgm_n   = 1'b1;
                    end
                end
            end
            ST_ERS_ARM: begin
                if (wr_en) state_n = cls.unl_a ? ST_ERS_UNL1 : idle_st;
            end
            ST_ERS_UNL1: begin
                if (wr_en) state_n = cls.unl_b ? ST_ERS_UNL2 : idle_st;
            end
            ST_ERS_UNL2: begin
                if (wr_en) begin
                    if (cls.c_conf) begin
                        state_n = ST_ERS_RUN;
                        ers_n   = 1'b1;
                        sect_n  = wr_addr[ADDR_W-1:SECT_LSB];
                    end else begin
                        state_n = idle_st;
                    end
                end
            end
            ST_IDREAD: begin
                if (wr_en && cls.c_reset) state_n = idle_st;
            end
            ST_PGM_RUN: begin
                if (eng_timeout)   state_n = ST_FAULT;
                else if (eng_done) state_n = idle_st;
            end
            ST_ERS_RUN: begin
                if (eng_timeout) begin
                    state_n = ST_FAULT;
                end else if (eng_done) begin
                    state_n  = ST_ARRAY;
                    mask_clr = 1'b1;
                end else if (wr_en && cls.c_susp) begin
                    state_n  = ST_SUSPEND;
                    susp_n   = 1'b1;
                    mask_set = 1'b1;
                    sreq_n   = 1'b1;
                end
            end
            ST_FAULT: begin
                if (wr_en && cls.c_reset) state_n = idle_st;
            end
            default: state_n = ST_ARRAY;
        endcase
    end

    // Register state, requests and the operands that go with them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_ARRAY;
            susp_q       <= 1'b0;
            sect_q       <= '0;
            pgm_start    <= 1'b0;
            erase_start  <= 1'b0;
            suspend_req  <= 1'b0;
            resume_req   <= 1'b0;
            pgm_addr     <= '0;
            pgm_data     <= '0;
        end else begin
            state_q      <= state_n;
            susp_q       <= susp_n;
            sect_q       <= sect_n;
            pgm_start    <= pgm_n;
            erase_start  <= ers_n;
            suspend_req  <= sreq_n;
            resume_req   <= rreq_n;
            if (pgm_n) begin
                pgm_addr <= wr_addr;
                pgm_data <= wr_data;
            end
        end
    end

    assign erase_sector = sect_q;

    // R1: reset leaves array reads and no requests.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (rd_mode == 2'b00) && !pgm_start && !erase_start &&
                   !suspend_req && !resume_req);

    // R2: at most one engine request per cycle.
    a_r2_one_request: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pgm_start, erase_start, suspend_req, resume_req}));

    // R7: a running program is kept until the engine reports.
    a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PGM_RUN && !eng_done && !eng_timeout) |=> rd_mode == 2'b01);

    // R4: ID reads persist until a reset write.
    a_r4_ident_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_mode == 2'b10 && !(wr_en && wr_data[7:0] == CMD_RESET)) |=> rd_mode == 2'b10);

    // R8: the fault state always reads status.
    a_r8_fault_status: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAULT) |-> rd_mode == 2'b01);

    // R10: resume is only requested out of erase suspend.
    a_r10_resume_source: assert property (@(posedge clk) disable iff (!rst_n)
        resume_req |-> $past(state_q) == ST_SUSPEND);
endmodule

// File: tb/test_flash_cmd_fsm.sv
// Scoreboard bench: the driver pushes expected values, the monitor pops and
// compares them on the falling clock edge.
module test_flash_cmd_fsm;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [16:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [16:0] rd_addr = '0;
    logic        eng_done = 1'b0;
    logic        eng_timeout = 1'b0;
    logic [1:0]  rd_mode;
    logic        pgm_start, erase_start, suspend_req, resume_req;
    logic [16:0] pgm_addr;
    logic [7:0]  pgm_data;
    logic [2:0]  erase_sector;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    localparam int K_MODE = 0, K_PGM = 1, K_ERS = 2, K_SUSP = 3, K_RES = 4,
                   K_SECT = 5, K_PADDR = 6, K_PDATA = 7;
    localparam logic [1:0] M_ARR = 2'b00, M_STS = 2'b01, M_ID = 2'b10;

    int          kq[$];
    logic [31:0] eq[$];
    string       rq[$];

    flash_cmd_fsm i_flash_cmd_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .eng_done(eng_done),
        .eng_timeout(eng_timeout), .rd_mode(rd_mode), .pgm_start(pgm_start),
        .pgm_addr(pgm_addr), .pgm_data(pgm_data), .erase_start(erase_start),
        .erase_sector(erase_sector), .suspend_req(suspend_req),
        .resume_req(resume_req)
    );

    always #2 clk = ~clk;

    function automatic logic [31:0] actual(int k);
        case (k)
            K_MODE:  return 32'(rd_mode);
            K_PGM:   return 32'(pgm_start);
            K_ERS:   return 32'(erase_start);
            K_SUSP:  return 32'(suspend_req);
            K_RES:   return 32'(resume_req);
            K_SECT:  return 32'(erase_sector);
            K_PADDR: return 32'(pgm_addr);
            default: return 32'(pgm_data);
        endcase
    endfunction

    // Monitor: compare every queued expectation at the falling edge.
    always @(negedge clk) begin
        while (kq.size() > 0) begin
            int k;
            logic [31:0] e, a;
            string r;
            k = kq.pop_front();
            e = eq.pop_front();
            r = rq.pop_front();
            a = actual(k);
            total++;
            if (a !== e) begin
                bad++;
                $display("FAIL %s kind=%0d actual=%0h expected=%0h", r, k, a, e);
            end
        end
    end

    task automatic chk(int k, logic [31:0] e, string r);
        kq.push_back(k);
        eq.push_back(e);
        rq.push_back(r);
        @(negedge clk);
        #1;
    endtask

    task automatic chk_rd(logic [16:0] a, logic [1:0] e, string r);
        rd_addr = a;
        chk(K_MODE, 32'(e), r);
    endtask

    task automatic wr(logic [16:0] a, logic [7:0] d);
        @(posedge clk);
        #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic unlock3(logic [7:0] c);
        wr(17'h05555, 8'hAA);
        wr(17'h02AAA, 8'h55);
        wr(17'h05555, c);
    endtask

    task automatic erase_seq(logic [16:0] a);
        unlock3(8'h80);
        wr(17'h05555, 8'hAA);
        wr(17'h02AAA, 8'h55);
        wr(a, 8'h30);
    endtask

    task automatic pulse_done();
        @(posedge clk);
        #1;
        eng_done = 1'b1;
        @(posedge clk);
        #1;
        eng_done = 1'b0;
    endtask

    task automatic pulse_timeout();
        @(posedge clk);
        #1;
        eng_timeout = 1'b1;
        @(posedge clk);
        #1;
        eng_timeout = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1 reset state
        chk_rd(17'h00000, M_ARR, "R1 mode");
        chk(K_PGM, 0, "R1 pgm_start");
        chk(K_ERS, 0, "R1 erase_start");

        // R2 program
        unlock3(8'hA0);
        wr(17'h01234, 8'h5A);
        chk(K_PGM, 1, "R2 pgm_start");
        chk(K_PADDR, 32'h01234, "R2 pgm_addr");
        chk(K_PDATA, 32'h5A, "R2 pgm_data");
        chk_rd(17'h01234, M_STS, "R2 busy status");
        wr(17'h00000, 8'hF0);
        chk_rd(17'h01234, M_STS, "R7 reset ignored in program");
        pulse_done();
        chk_rd(17'h01234, M_ARR, "R2 array after done");

        // R5 wrong data, wrong address
        wr(17'h05555, 8'hAA);
        wr(17'h02AAA, 8'h11);
        wr(17'h02AAA, 8'h55);
        wr(17'h05555, 8'hA0);
        wr(17'h00100, 8'h77);
        chk(K_PGM, 0, "R5 wrong data aborts");
        wr(17'h05555, 8'hAA);
        wr(17'h01111, 8'h55);
        wr(17'h05555, 8'hA0);
        wr(17'h00200, 8'h66);
        chk(K_PGM, 0, "R5 wrong address aborts");
        chk_rd(17'h00200, M_ARR, "R5 array");

        // R6 reset between cycles
        wr(17'h05555, 8'hAA);
        wr(17'h02AAA, 8'h55);
        wr(17'h00000, 8'hF0);
        wr(17'h05555, 8'h90);
        chk_rd(17'h00000, M_ARR, "R6 reset mid sequence");

        // R4 autoselect
        unlock3(8'h90);
        chk_rd(17'h00000, M_ID, "R4 ident entered");
        wr(17'h05555, 8'hAA);
        wr(17'h00000, 8'h00);
        chk_rd(17'h00000, M_ID, "R4 ident held");
        wr(17'h1FFFF, 8'hF0);
        chk_rd(17'h00000, M_ARR, "R4 reset leaves ident");

        // R10 suspend/resume ignored when idle
        wr(17'h00000, 8'hB0);
        chk(K_SUSP, 0, "R10 no suspend");
        wr(17'h00000, 8'h30);
        chk(K_RES, 0, "R10 no resume");
        chk_rd(17'h0C000, M_ARR, "R10 array kept");

        // R3 erase sector 3
        erase_seq(17'h0C000);
        chk(K_ERS, 1, "R3 erase_start");
        chk(K_SECT, 3, "R3 erase_sector");
        chk_rd(17'h00000, M_STS, "R3 busy status");
        wr(17'h00000, 8'hF0);
        chk_rd(17'h00000, M_STS, "R7 reset ignored in erase");

        // R9 suspend
        wr(17'h00000, 8'hB0);
        chk(K_SUSP, 1, "R9 suspend_req");
        chk_rd(17'h0C123, M_STS, "R9 suspended sector status");
        chk_rd(17'h10000, M_ARR, "R9 other sector array");

        // R11 program during suspend
        unlock3(8'hA0);
        wr(17'h10004, 8'h3C);
        chk(K_PGM, 1, "R11 pgm_start in suspend");
        chk_rd(17'h10004, M_STS, "R11 busy status");
        pulse_done();
        chk_rd(17'h0C000, M_STS, "R11 suspended sector status");
        chk_rd(17'h00000, M_ARR, "R11 other sector array");

        // R12 autoselect from suspend
        unlock3(8'h90);
        chk_rd(17'h00000, M_ID, "R12 ident in suspend");
        wr(17'h00000, 8'hF0);
        chk_rd(17'h0C000, M_STS, "R12 back to suspend status");
        chk_rd(17'h14000, M_ARR, "R12 back to suspend array");

        // R9 resume
        wr(17'h00000, 8'h30);
        chk(K_RES, 1, "R9 resume_req");
        chk_rd(17'h00000, M_STS, "R9 status after resume");

        // R13 erase completes
        pulse_done();
        chk_rd(17'h0C000, M_ARR, "R13 array in erased sector");
        chk_rd(17'h00000, M_ARR, "R13 array elsewhere");

        // R8 timeout on erase of sector 7
        erase_seq(17'h1C000);
        chk(K_SECT, 7, "R3 erase_sector top");
        pulse_timeout();
        chk_rd(17'h00000, M_STS, "R8 fault status");
        wr(17'h00000, 8'h00);
        chk_rd(17'h00000, M_STS, "R8 fault held");
        wr(17'h00000, 8'hF0);
        chk_rd(17'h00000, M_ARR, "R8 reset clears fault");

        repeat (2) @(posedge clk);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule